// File: doc/BRIEF.md
# Vector predicated branch condition evaluator

This block turns a vector of condition-register field bits into a single branch decision. After a start pulse it walks the vector one element per cycle, from index 0 up to the vector length minus one. For each element it fetches one 4-bit condition field over a request/valid read port. A per-element predicate bit decides how the element is treated. A masked-out element is either skipped or replaced by a fixed substitute bit. The element results are then combined with AND (all must pass) or OR (any may pass), and the walk stops early as soon as the outcome is settled.

The walk has three side effects. It can count down a loop-count register, under one of three policies. It can cut the vector length at the decision point, including or excluding the current element, and either on a pass or on a fail. It can write a return address to the link register, either always or only when the branch is taken. All results are registered and become valid together with a one-cycle `done` pulse. The caller owns the register files and instruction fetch: it supplies the current PC, count and field contents, and it commits `ctr_out`, `vl_out` and the link write.

Top module: `vec_branch_eval`

## Requirements
- R1: A `start` seen while `busy` is low latches every operand and begins a walk. `busy` stays high until the cycle in which `done` rises. A `start` seen while `busy` is high is ignored and does not alter the running walk.
- R2: The tested bit of a field is `cr_data[bi_sel]`, with 0=LT, 1=GT, 2=EQ and 3=SO. The field index of element i is `(bi_base + i) mod 128`. An element passes when `bo_always | ~(testbit ^ bo_sense)` holds and the count check also holds.
- R3: In ALL mode the decision starts at 1, is ANDed with each element result, and the walk stops at the first failing element. In ANY mode the decision starts at 0, is ORed with each result, and the walk stops at the first passing element. No field beyond the stop point is requested.
- R4: With a vector length of 0, `taken` equals `all_mode` and no field is requested.
- R5: For a masked-out element with `sz=1`, the tested bit is `snz` and no field is read. With `sz=0` the element is skipped: it is not read and has no effect apart from the count exception in R6.
- R6: The count check is `bo_noctr | ((CTR != 0) ^ bo_ctrz)`. It uses the count value held before this element's decrement, and only the low 32 bits when `mode32=1`. With `bo_noctr=0`, a tested element decrements the count as follows: always when `ctr_test=0`; on a pass of the condition when `ctr_test=1, cti=0`; on a fail when `ctr_test=1, cti=1`. A skipped element decrements only when `ctr_test=0, cti=1`. With `bo_noctr=1` the count never changes.
- R7: With `vlset=1`, an element whose result equals `vsb` ends the walk and truncates the length. With `vli=1` the new length is index+1. With `vli=0` the new length is one past the last tested element before it, so skipped elements just before it are excluded.
- R8: When truncation fires with `vli=0`, that element does not decrement the count. With `vli=1` the decrement is applied first.
- R9: The target is the sign-extended `{disp,2'b00}`. It is used as is when `abs_addr=1` and added to `pc_in` otherwise. `lr_data` is `pc_in+8`. `lr_we` is `link & (~lru | taken)`.
- R10: With `bi_scalar=1`, every read uses field `bi_base` and the walk stops after the first tested element. Skipped elements before it do not stop the walk.
- R11: `done` is a one-cycle pulse. Outputs hold until the next `done`. When no truncation fires, `vl_out` equals the latched length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk when idle |
| busy | output | 1 | Walk in progress |
| vl_in | input | 7 | Vector length, at most 64 |
| pred_mask | input | 64 | Predicate bit per element |
| bo_always | input | 1 | Condition forced true |
| bo_sense | input | 1 | Bit value that passes |
| bo_noctr | input | 1 | Count neither decremented nor tested |
| bo_ctrz | input | 1 | Count check passes on zero |
| bi_base | input | 7 | Base condition field index |
| bi_sel | input | 2 | Bit within the field |
| bi_scalar | input | 1 | Field operand is scalar |
| abs_addr | input | 1 | Target is absolute |
| link | input | 1 | Link register write requested |
| disp | input | 14 | Word displacement |
| all_mode | input | 1 | 1 = AND of all results, 0 = OR |
| snz | input | 1 | Substitute bit for masked-out elements |
| sz | input | 1 | 1 = substitute masked-out elements, 0 = skip them |
| ctr_test | input | 1 | Count decrement follows the condition |
| cti | input | 1 | Inverts the decrement policy |
| vlset | input | 1 | Length truncation enabled |
| vsb | input | 1 | Result value that triggers truncation |
| vli | input | 1 | Truncation includes the current element |
| lru | input | 1 | Link write only when taken |
| mode32 | input | 1 | Count check on the low 32 bits |
| pc_in | input | 64 | Address of the branch instruction |
| ctr_in | input | 64 | Count register value |
| cr_req | output | 1 | Field read request |
| cr_idx | output | 7 | Field index requested |
| cr_valid | input | 1 | Field data valid for the request |
| cr_data | input | 4 | Field contents |
| done | output | 1 | Result pulse |
| taken | output | 1 | Branch decision |
| target_pc | output | 64 | Branch target |
| lr_we | output | 1 | Link register write enable |
| lr_data | output | 64 | Return address |
| ctr_out | output | 64 | Updated count |
| vl_out | output | 7 | Updated vector length |

## Verification
The assertions assume `vl_in` never exceeds 64. They also assume `cr_valid` is raised only while `cr_req` is high and `cr_data` then holds the requested field. The stimulus keeps vector lengths between 0 and 6. The field responder answers only open requests, from a per-run table, and stalls on about a quarter of the cycles. Operand inputs change only while the block is idle, except in one deliberate test where `start` and other operands are disturbed mid-walk.

// File: rtl/vbe_pkg.sv
package vbe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1
  } vbe_state_e;

  typedef struct packed {
    logic always_t;
    logic sense;
    logic noctr;
    logic ctrz;
    logic all_mode;
    logic snz;
    logic sz;
    logic ctr_test;
    logic cti;
    logic vlset;
    logic vsb;
    logic vli;
    logic lru;
    logic mode32;
  } vbe_mode_t;

  // condition of one element from its tested bit
  function automatic logic f_el_ok(input logic testbit, input vbe_mode_t m);
    return m.always_t | ~(testbit ^ m.sense);
  endfunction

  // decrement policy for a tested element
  function automatic logic f_tested_dec(input logic el_ok, input vbe_mode_t m);
    return ~m.noctr & (~m.ctr_test | (el_ok ^ m.cti));
  endfunction

  // decrement policy for a skipped element
  function automatic logic f_skip_dec(input vbe_mode_t m);
    return ~m.noctr & ~m.ctr_test & m.cti;
  endfunction

endpackage

// File: rtl/vbe_elem.sv
module vbe_elem
  import vbe_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  vbe_mode_t       m,
  input  logic            testbit,
  input  logic [XLEN-1:0] ctr,
  output logic            el_ok,
  output logic            res,
  output logic            dec,
  output logic            trunc
);
  logic ctr_nz;
  logic ctr_ok;

  always_comb begin
    ctr_nz = m.mode32 ? (ctr[31:0] != 32'd0) : (ctr != '0);
    ctr_ok = m.noctr | (ctr_nz ^ m.ctrz);
    el_ok  = f_el_ok(testbit, m);
    res    = el_ok & ctr_ok;
    dec    = f_tested_dec(el_ok, m);
    trunc  = m.vlset & (res == m.vsb);
  end
endmodule

// File: rtl/vbe_target.sv
module vbe_target #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 14
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              abs_addr,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   ret
);
  localparam int OFFW = DISP_W + 2;
  logic [XLEN-1:0] off;

  always_comb begin
    off    = {{(XLEN-OFFW){disp[DISP_W-1]}}, disp, 2'b00};
    target = abs_addr ? off : pc + off;
    ret    = pc + XLEN'(8);
  end
endmodule

// File: rtl/vec_branch_eval.sv
module vec_branch_eval
  import vbe_pkg::*;
#(
  parameter int VL_MAX  = 64,
  parameter int XLEN    = 64,
  parameter int CRF_CNT = 128,
  parameter int DISP_W  = 14,
  localparam int VLW    = $clog2(VL_MAX + 1),
  localparam int IDXW   = $clog2(VL_MAX),
  localparam int CRIW   = $clog2(CRF_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  input  logic [VLW-1:0]    vl_in,
  input  logic [VL_MAX-1:0] pred_mask,
  input  logic              bo_always,
  input  logic              bo_sense,
  input  logic              bo_noctr,
  input  logic              bo_ctrz,
  input  logic [CRIW-1:0]   bi_base,
  input  logic [1:0]        bi_sel,
  input  logic              bi_scalar,
  input  logic              abs_addr,
  input  logic              link,
  input  logic [DISP_W-1:0] disp,
  input  logic              all_mode,
  input  logic              snz,
  input  logic              sz,
  input  logic              ctr_test,
  input  logic              cti,
  input  logic              vlset,
  input  logic              vsb,
  input  logic              vli,
  input  logic              lru,
  input  logic              mode32,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   ctr_in,
  output logic              cr_req,
  output logic [CRIW-1:0]   cr_idx,
  input  logic              cr_valid,
  input  logic [3:0]        cr_data,
  output logic              done,
  output logic              taken,
  output logic [XLEN-1:0]   target_pc,
  output logic              lr_we,
  output logic [XLEN-1:0]   lr_data,
  output logic [XLEN-1:0]   ctr_out,
  output logic [VLW-1:0]    vl_out
);

  vbe_state_e        st;
  vbe_mode_t         m_in, m_r;
  logic [VLW-1:0]    idx, keep, vl_r;
  logic              acc;
  logic [XLEN-1:0]   ctr_r;
  logic [VL_MAX-1:0] mask_r;
  logic [CRIW-1:0]   base_r;
  logic [1:0]        sel_r;
  logic              scalar_r;
  logic [XLEN-1:0]   pc_r;
  logic [DISP_W-1:0] disp_r;
  logic              abs_r, link_r;

  // named internal events, observed by the checker
  logic walking, in_range, pbit, skip;
  logic ev_fire, ev_skip, ev_exhaust, trunc_now, stop_el, finish;
  logic testbit, el_ok, el_res, el_dec, el_trunc, skip_dec;
  logic acc_next, acc_final;
  logic [XLEN-1:0] ctr_after, ctr_final;
  logic [VLW-1:0]  vl_final;
  logic [XLEN-1:0] tgt_w, ret_w;
  logic [CRIW-1:0] cr_step;

  always_comb begin
    m_in = '{always_t: bo_always, sense: bo_sense, noctr: bo_noctr, ctrz: bo_ctrz,
             all_mode: all_mode, snz: snz, sz: sz, ctr_test: ctr_test, cti: cti,
             vlset: vlset, vsb: vsb, vli: vli, lru: lru, mode32: mode32};
  end

  assign busy     = (st == ST_WALK);
  assign walking  = busy;
  assign in_range = (idx < vl_r);
  assign pbit     = in_range ? mask_r[idx[IDXW-1:0]] : 1'b0;
  assign skip     = ~pbit & ~m_r.sz;
  assign cr_step  = scalar_r ? '0 : CRIW'(idx);
  assign cr_idx   = base_r + cr_step;
  assign cr_req   = walking & in_range & pbit;
  assign testbit  = pbit ? cr_data[sel_r] : m_r.snz;

  vbe_elem #(.XLEN(XLEN)) u_elem (
    .m       (m_r),
    .testbit (testbit),
    .ctr     (ctr_r),
    .el_ok   (el_ok),
    .res     (el_res),
    .dec     (el_dec),
    .trunc   (el_trunc)
  );

  vbe_target #(.XLEN(XLEN), .DISP_W(DISP_W)) u_target (
    .pc       (pc_r),
    .disp     (disp_r),
    .abs_addr (abs_r),
    .target   (tgt_w),
    .ret      (ret_w)
  );

  always_comb begin
    ev_fire    = walking & in_range & ~skip & (~pbit | cr_valid);
    ev_skip    = walking & in_range & skip;
    ev_exhaust = walking & ~in_range;
    skip_dec   = ev_skip & f_skip_dec(m_r);
    trunc_now  = ev_fire & el_trunc;
    stop_el    = ev_fire & (el_trunc | (m_r.all_mode != el_res) | scalar_r);
    finish     = ev_exhaust | stop_el;
    acc_next   = m_r.all_mode ? (acc & el_res) : (acc | el_res);
    acc_final  = ev_fire ? acc_next : acc;
    ctr_after  = (ev_fire & el_dec) ? ctr_r - XLEN'(1) : ctr_r;
    ctr_final  = (trunc_now & ~m_r.vli) ? ctr_r : ctr_after;
    if (trunc_now) vl_final = m_r.vli ? idx + VLW'(1) : keep;
    else           vl_final = vl_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      m_r       <= '0;
      idx       <= '0;
      keep      <= '0;
      vl_r      <= '0;
      acc       <= 1'b0;
      ctr_r     <= '0;
      mask_r    <= '0;
      base_r    <= '0;
      sel_r     <= '0;
      scalar_r  <= 1'b0;
      pc_r      <= '0;
      disp_r    <= '0;
      abs_r     <= 1'b0;
      link_r    <= 1'b0;
      done      <= 1'b0;
      taken     <= 1'b0;
      target_pc <= '0;
      lr_we     <= 1'b0;
      lr_data   <= '0;
      ctr_out   <= '0;
      vl_out    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st       <= ST_WALK;
            m_r      <= m_in;
            idx      <= '0;
            keep     <= '0;
            vl_r     <= vl_in;
            acc      <= all_mode;
            ctr_r    <= ctr_in;
            mask_r   <= pred_mask;
            base_r   <= bi_base;
            sel_r    <= bi_sel;
            scalar_r <= bi_scalar;
            pc_r     <= pc_in;
            disp_r   <= disp;
            abs_r    <= abs_addr;
            link_r   <= link;
          end
        end
        ST_WALK: begin
          if (finish) begin
            st        <= ST_IDLE;
            done      <= 1'b1;
            taken     <= acc_final;
            target_pc <= tgt_w;
            lr_we     <= link_r & (~m_r.lru | acc_final);
            lr_data   <= ret_w;
            ctr_out   <= ctr_final;
            vl_out    <= vl_final;
          end else if (ev_fire) begin
            acc   <= acc_next;
            ctr_r <= ctr_after;
            keep  <= idx + VLW'(1);
            idx   <= idx + VLW'(1);
          end else if (ev_skip) begin
            if (skip_dec) ctr_r <= ctr_r - XLEN'(1);
            idx <= idx + VLW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vbe_checker.sv
module vbe_checker #(
  parameter int VLW    = 7,
  parameter int XLEN   = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            taken,
  input logic            lr_we,
  input logic            cr_req,
  input logic            ev_fire,
  input logic            ev_skip,
  input logic            ev_exhaust,
  input logic [VLW-1:0]  vl_in,
  input logic [VLW-1:0]  vl_out,
  input logic            bo_noctr,
  input logic            all_mode,
  input logic            lru,
  input logic [XLEN-1:0] ctr_in,
  input logic [XLEN-1:0] ctr_out
);
  logic [VLW-1:0]  cap_vl;
  logic [XLEN-1:0] cap_ctr;
  logic            cap_noctr, cap_all, cap_lru;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vl <= '0; cap_ctr <= '0; cap_noctr <= 1'b0; cap_all <= 1'b0; cap_lru <= 1'b0;
    end else if (start && !busy) begin
      cap_vl <= vl_in; cap_ctr <= ctr_in; cap_noctr <= bo_noctr;
      cap_all <= all_mode; cap_lru <= lru;
    end
  end

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cr_req |-> busy); // R1
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R1
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_fire, ev_skip, ev_exhaust})); // R3
  AST_VL0_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_vl == '0) |-> (taken == cap_all)); // R4
  AST_CTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_noctr) |-> (ctr_out == cap_ctr)); // R6
  AST_VL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= cap_vl)); // R7
  AST_LR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lr_we && cap_lru) |-> taken); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
endmodule

bind vec_branch_eval vbe_checker #(.VLW(VLW), .XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .taken      (taken),
  .lr_we      (lr_we),
  .cr_req     (cr_req),
  .ev_fire    (ev_fire),
  .ev_skip    (ev_skip),
  .ev_exhaust (ev_exhaust),
  .vl_in      (vl_in),
  .vl_out     (vl_out),
  .bo_noctr   (bo_noctr),
  .all_mode   (all_mode),
  .lru        (lru),
  .ctr_in     (ctr_in),
  .ctr_out    (ctr_out)
);

// File: tb/vec_branch_eval_bench.sv
module vec_branch_eval_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy;
  logic [6:0]  vl_in = '0;
  logic [63:0] pred_mask = '0;
  logic bo_always = 0, bo_sense = 0, bo_noctr = 0, bo_ctrz = 0;
  logic [6:0]  bi_base = '0;
  logic [1:0]  bi_sel = '0;
  logic bi_scalar = 0, abs_addr = 0, link = 0;
  logic [13:0] disp = '0;
  logic all_mode = 0, snz = 0, sz = 0, ctr_test = 0, cti = 0;
  logic vlset = 0, vsb = 0, vli = 0, lru = 0, mode32 = 0;
  logic [63:0] pc_in = '0, ctr_in = '0;
  logic        cr_req;
  logic [6:0]  cr_idx;
  logic        cr_valid = 1'b0;
  logic [3:0]  cr_data = '0;
  logic        done, taken, lr_we;
  logic [63:0] target_pc, lr_data, ctr_out;
  logic [6:0]  vl_out;

  int errors = 0;
  int checks = 0;
  int reads = 0;
  int cycles = 0;
  logic [31:0] stall_s = 32'h1234_5677;
  logic [31:0] seed = 32'hACE1_0001;
  logic [3:0]  crm [128];

  logic        exp_taken, exp_lrwe;
  logic [63:0] exp_ctr, exp_tgt, exp_ret;
  int          exp_vl, exp_reads;

  vec_branch_eval u_vec_branch_eval (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] mix(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=%0d expected<=190000", cycles);
      summary();
      $finish;
    end
  end

  // field responder: answers open requests, stalls about one cycle in four
  always @(negedge clk) begin
    stall_s  = mix(stall_s);
    cr_valid = cr_req && (stall_s[1:0] != 2'b00);
    cr_data  = crm[cr_idx];
    if (cr_req && cr_valid) reads++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference result computed from the requirements
  task automatic model();
    logic        acc;
    logic [63:0] c;
    logic [15:0] off16;
    int v, kp, rd;
    bit stop;
    acc = all_mode; c = ctr_in; v = int'(vl_in); kp = 0; rd = 0; stop = 0;
    for (int i = 0; i < int'(vl_in) && !stop; i++) begin
      logic tb, cz, cok, eok, r, dd;
      if (!pred_mask[i] && !sz) begin
        if (!bo_noctr && !ctr_test && cti) c = c - 64'd1;
        continue;
      end
      if (pred_mask[i]) begin
        tb = crm[7'(int'(bi_base) + (bi_scalar ? 0 : i))][bi_sel];
        rd++;
      end else tb = snz;
      cz  = mode32 ? (c[31:0] != 0) : (c != 0);
      cok = bo_noctr | (cz ^ bo_ctrz);
      eok = bo_always | (tb == bo_sense);
      r   = eok & cok;
      acc = all_mode ? (acc & r) : (acc | r);
      dd  = !bo_noctr && (!ctr_test || (eok != cti));
      if (vlset && (r == vsb)) begin
        if (vli) begin
          if (dd) c = c - 64'd1;
          v = i + 1;
        end else v = kp;
        stop = 1;
      end else begin
        if (dd) c = c - 64'd1;
        if (all_mode != r) stop = 1;
        if (bi_scalar) stop = 1;
        kp = i + 1;
      end
    end
    exp_taken = acc; exp_ctr = c; exp_vl = v; exp_reads = rd;
    exp_lrwe  = link & (!lru | acc);
    off16     = {disp, 2'b00};
    exp_tgt   = abs_addr ? 64'($signed(off16)) : pc_in + 64'($signed(off16));
    exp_ret   = pc_in + 64'd8;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 done missing actual=0 expected=1");
    end
  endtask

  task automatic run_one();
    model();
    @(negedge clk);
    reads = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", 64'(busy), 64'd1);
    wait_done();
    chk("R2/R3/R10 taken", 64'(taken), 64'(exp_taken));
    chk("R6/R8 ctr_out", ctr_out, exp_ctr);
    chk("R7/R8/R11 vl_out", 64'(vl_out), 64'(exp_vl));
    chk("R3/R5 field reads", 64'(reads), 64'(exp_reads));
    chk("R9 lr_we", 64'(lr_we), 64'(exp_lrwe));
    chk("R9 target", target_pc, exp_tgt);
    if (exp_lrwe) chk("R9 lr_data", lr_data, exp_ret);
    @(negedge clk);
    chk("R11 done one cycle", 64'(done), 64'd0);
    chk("R11 outputs hold", 64'(vl_out), 64'(exp_vl));
  endtask

  task automatic fill_cr(input logic [31:0] s);
    logic [31:0] h;
    h = s;
    for (int k = 0; k < 128; k++) begin
      h = mix(h);
      crm[k] = h[7:4];
    end
  endtask

  task automatic clear_modes();
    {bo_always, bo_sense, bo_noctr, bo_ctrz, all_mode, snz, sz, ctr_test, cti,
     vlset, vsb, vli, lru, mode32, bi_scalar, abs_addr, link} = '0;
    bi_base = '0; bi_sel = '0; disp = '0; pc_in = 64'h1000; ctr_in = 64'd10;
  endtask

  initial begin
    fill_cr(seed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", 64'(busy), 64'd0);
    chk("R11 reset done", 64'(done), 64'd0);
    chk("R1 reset cr_req", 64'(cr_req), 64'd0);
    chk("R11 reset vl_out", 64'(vl_out), 64'd0);

    // R7 worked example: mask 110010, failure at element 4
    clear_modes();
    bo_noctr = 1; bo_sense = 1; vlset = 1; vsb = 0; all_mode = 1; snz = 1;
    vl_in = 7'd6; pred_mask = 64'b110010; bi_sel = 2'd0;
    for (int k = 0; k < 128; k++) crm[k] = 4'hF;
    crm[4] = 4'hE;
    sz = 0; vli = 0; run_one();
    chk("R7 exclusive skip example", 64'(vl_out), 64'd2);
    chk("R3 no read past exit", 64'(reads), 64'd2);
    sz = 1; vli = 0; run_one();
    chk("R7 exclusive zeroing example", 64'(vl_out), 64'd4);
    sz = 0; vli = 1; run_one();
    chk("R7 inclusive example", 64'(vl_out), 64'd5);

    // R4 zero length
    clear_modes(); vl_in = 7'd0; pred_mask = '1;
    all_mode = 1; run_one();
    chk("R4 empty ALL taken", 64'(taken), 64'd1);
    all_mode = 0; run_one();
    chk("R4 empty ANY not taken", 64'(taken), 64'd0);
    chk("R4 empty no reads", 64'(reads), 64'd0);

    // R9 absolute target with negative displacement, link written
    clear_modes(); vl_in = 7'd0; all_mode = 1; abs_addr = 1; link = 1; disp = 14'h2001;
    pc_in = 64'h0000_0000_0040_0000; run_one();
    chk("R9 absolute target", target_pc, 64'hFFFF_FFFF_FFFF_8004);
    chk("R9 return address", lr_data, 64'h0000_0000_0040_0008);

    // R1 start ignored while busy
    clear_modes(); bo_noctr = 1; bo_sense = 1; all_mode = 1; vl_in = 7'd6;
    pred_mask = '1;
    for (int k = 0; k < 128; k++) crm[k] = 4'hF;
    @(negedge clk); reads = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; vl_in = 7'd0; all_mode = 0;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk("R1 restart ignored taken", 64'(taken), 64'd1);
    chk("R1 restart ignored vl", 64'(vl_out), 64'd6);
    chk("R1 restart ignored reads", 64'(reads), 64'd6);
    @(negedge clk);

    // near-exhaustive sweep of the twelve mode bits
    for (int k = 0; k < 4096; k++) begin
      logic [31:0] r, r2;
      seed = mix(seed); r = seed;
      seed = mix(seed); r2 = seed;
      {bo_always, bo_sense, bo_noctr, bo_ctrz, all_mode, snz, sz, ctr_test, cti,
       vlset, vsb, vli} = 12'(k);
      vl_in     = 7'(r[2:0] % 7);
      pred_mask = {58'd0, r[13:8]};
      bi_base   = r[20] ? 7'd125 : 7'(r[19:14]);
      bi_sel    = r[22:21];
      bi_scalar = (r[25:23] == 3'd0);
      abs_addr  = r[26];
      link      = r[27];
      lru       = r[28];
      mode32    = r[29];
      case (r[31:30])
        2'd0: ctr_in = 64'd0;
        2'd1: ctr_in = 64'd2;
        2'd2: ctr_in = 64'h1_0000_0000;
        default: ctr_in = 64'h1_0000_0001;
      endcase
      disp  = r2[13:0];
      pc_in = {r2, r2[31:3], 3'b000};
      fill_cr(r2 ^ r);
      run_one();
    end

    summary();
    $finish;
  end
endmodule